// File: doc/BRIEF.md
# Segment Register Load Privilege Checker

This block decides whether a 16-bit selector may be placed in a segment register when a stack pop or a register move names that register as its destination. The pipeline presents one request per cycle with a valid strobe: the destination register number, the selector, the current privilege level (CPL), and the descriptor fields that an outside table walk has already fetched (present, segment kind, readable, writable and descriptor privilege level DPL). One cycle later the block returns a registered verdict: accept, or a general-protection fault with a code that says which rule failed. It also returns the selector split into its index, table-indicator and requested-privilege (RPL) fields.

The rules depend on the destination. The code-segment register can never be written by this path. The stack-segment register needs a writable data segment and an exact match of RPL, DPL and CPL. The four data registers allow a null selector, require readable code when code is loaded, and apply an inequality on privilege that conforming code segments skip. A small state machine with two states produces the done pulse: `ST_IDLE` (no result) moves to `ST_DONE` on a valid strobe, `ST_DONE` stays in `ST_DONE` on another strobe (back-to-back requests) and returns to `ST_IDLE` when the strobe is low.

Top module: `seg_load_guard`

## Requirements
- R1: A request sampled with `ld_valid` high gives `res_done` high in the next cycle only; `res_done` is low in any cycle after a cycle without a request, and low after reset.
- R2: While `res_done` is high exactly one of `res_accept` and `res_fault` is high, and `res_accept` is high exactly when `res_code` is 0; while `res_done` is low both are low and `res_code` is 0.
- R3: Destination code 1 (code-segment register) always faults with code 1, whatever the selector and descriptor.
- R4: Destination codes 6 and 7 name no register and fault with code 6. Codes 0, 3, 4, 5 are the data registers; code 2 is the stack-segment register.
- R5: A null selector (bits 15:2 all zero, any RPL) faults with code 2 for the stack register and is accepted for any data register regardless of the descriptor fields.
- R6: For the stack register the descriptor kind must be data (kind 0) with the writable bit set, else fault code 3.
- R7: For the stack register both RPL (selector bits 1:0) and DPL must equal CPL, else fault code 4.
- R8: For a data register, kind 3 (system) faults with code 3, and a code kind (1 nonconforming, 2 conforming) without the readable bit faults with code 3.
- R9: For a data register loaded with data or nonconforming code, RPL greater than DPL or CPL greater than DPL faults with code 4.
- R10: For a data register loaded with readable conforming code the privilege comparison is skipped.
- R11: A non-null request that passes the kind and privilege rules but whose descriptor is not present faults with code 5.
- R12: The registered fields are index = selector bits 15:3, table indicator = bit 2, RPL = bits 1:0, updated with each result.
- R13: When several rules fail, the code reported follows the order: destination (codes 6, 1), null, kind (3), privilege (4), presence (5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Request strobe |
| ld_target | input | 3 | Destination register number |
| ld_sel | input | 16 | Selector to load |
| cur_cpl | input | 2 | Current privilege level |
| dsc_present | input | 1 | Descriptor present bit |
| dsc_kind | input | 2 | Segment kind: 0 data, 1 nonconforming code, 2 conforming code, 3 system |
| dsc_readable | input | 1 | Code segment readable |
| dsc_writable | input | 1 | Data segment writable |
| dsc_dpl | input | 2 | Descriptor privilege level |
| res_done | output | 1 | Result valid pulse |
| res_accept | output | 1 | Load allowed |
| res_fault | output | 1 | General-protection fault |
| res_code | output | 3 | Fault code, 0 when accepted |
| res_index | output | 13 | Selector index |
| res_ti | output | 1 | Selector table indicator |
| res_rpl | output | 2 | Selector requested privilege level |

## Verification
The bench aims at the null selector, which a wrong design might test including the RPL bits (so a selector of value 3 would fault) or treat alike for stack and data registers. It drives conforming code at a DPL below CPL, which a design that forgot the skip would reject, and requests that break several rules at once, where a wrong priority order returns the wrong code. Back-to-back requests catch a done pulse that drops between results, and random requests with RPL, CPL and DPL chosen near each other catch an inequality written in the wrong direction.

// File: rtl/seg_load_pkg.sv
package seg_load_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } chk_state_e;

    typedef enum logic [2:0] {
        FC_NONE    = 3'd0,
        FC_CS_LOAD = 3'd1,
        FC_NULL_SS = 3'd2,
        FC_KIND    = 3'd3,
        FC_PRIV    = 3'd4,
        FC_ABSENT  = 3'd5,
        FC_BAD_TGT = 3'd6
    } fault_e;

    typedef enum logic [1:0] {
        DK_DATA    = 2'd0,
        DK_CODE_NC = 2'd1,
        DK_CODE_CF = 2'd2,
        DK_SYSTEM  = 2'd3
    } dkind_e;

    typedef enum logic [1:0] {
        TC_DATA_REG = 2'd0,
        TC_STACK    = 2'd1,
        TC_CODE     = 2'd2,
        TC_INVALID  = 2'd3
    } tclass_e;

    localparam logic [2:0] TGT_ES = 3'd0;
    localparam logic [2:0] TGT_CS = 3'd1;
    localparam logic [2:0] TGT_SS = 3'd2;
    localparam logic [2:0] TGT_DS = 3'd3;
    localparam logic [2:0] TGT_FS = 3'd4;
    localparam logic [2:0] TGT_GS = 3'd5;

endpackage

// File: rtl/sel_decode.sv
module sel_decode #(
    parameter int SEL_W = 16,
    parameter int RPL_W = 2,
    localparam int IDX_W = SEL_W - RPL_W - 1
) (
    input  logic [SEL_W-1:0] sel,
    output logic [IDX_W-1:0] index,
    output logic             ti,
    output logic [RPL_W-1:0] rpl,
    output logic             is_null
);
    assign index   = sel[SEL_W-1:RPL_W+1];
    assign ti      = sel[RPL_W];
    assign rpl     = sel[RPL_W-1:0];
    assign is_null = (sel[SEL_W-1:RPL_W] == '0);
endmodule

// File: rtl/tgt_classify.sv
module tgt_classify
    import seg_load_pkg::*;
(
    input  logic [2:0] target,
    output tclass_e    tclass
);
    always_comb begin
        unique case (target)
            TGT_ES, TGT_DS, TGT_FS, TGT_GS: tclass = TC_DATA_REG;
            TGT_SS:                         tclass = TC_STACK;
            TGT_CS:                         tclass = TC_CODE;
            default:                        tclass = TC_INVALID;
        endcase
    end
endmodule

// File: rtl/priv_rules.sv
module priv_rules
    import seg_load_pkg::*;
#(
    parameter int RPL_W = 2
) (
    input  tclass_e          tclass,
    input  logic             is_null,
    input  logic [RPL_W-1:0] rpl,
    input  logic [RPL_W-1:0] cpl,
    input  logic [RPL_W-1:0] dpl,
    input  logic             present,
    input  dkind_e           kind,
    input  logic             readable,
    input  logic             writable,
    output fault_e           code
);
    logic stack_kind_bad;
    logic stack_priv_bad;
    logic data_kind_bad;
    logic data_priv_bad;

    assign stack_kind_bad = (kind != DK_DATA) || !writable;
    assign stack_priv_bad = (rpl != cpl) || (dpl != cpl);
    assign data_kind_bad  = (kind == DK_SYSTEM) || ((kind != DK_DATA) && !readable);
    assign data_priv_bad  = (kind != DK_CODE_CF) && ((rpl > dpl) || (cpl > dpl));

    always_comb begin
        code = FC_NONE;
        unique case (tclass)
            TC_INVALID: code = FC_BAD_TGT;
            TC_CODE:    code = FC_CS_LOAD;
            TC_STACK: begin
                if (is_null)             code = FC_NULL_SS;
                else if (stack_kind_bad) code = FC_KIND;
                else if (stack_priv_bad) code = FC_PRIV;
                else if (!present)       code = FC_ABSENT;
            end
            TC_DATA_REG: begin
                if (is_null)             code = FC_NONE;
                else if (data_kind_bad)  code = FC_KIND;
                else if (data_priv_bad)  code = FC_PRIV;
                else if (!present)       code = FC_ABSENT;
            end
            default: code = FC_BAD_TGT;
        endcase
    end
endmodule

// File: rtl/seg_load_guard.sv
module seg_load_guard
    import seg_load_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int RPL_W = 2,
    localparam int IDX_W = SEL_W - RPL_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_valid,
    input  logic [2:0]       ld_target,
    input  logic [SEL_W-1:0] ld_sel,
    input  logic [RPL_W-1:0] cur_cpl,
    input  logic             dsc_present,
    input  logic [1:0]       dsc_kind,
    input  logic             dsc_readable,
    input  logic             dsc_writable,
    input  logic [RPL_W-1:0] dsc_dpl,
    output logic             res_done,
    output logic             res_accept,
    output logic             res_fault,
    output logic [2:0]       res_code,
    output logic [IDX_W-1:0] res_index,
    output logic             res_ti,
    output logic [RPL_W-1:0] res_rpl
);
    chk_state_e       state_q, state_d;
    tclass_e          tclass;
    fault_e           verdict;
    fault_e           code_q;
    logic [IDX_W-1:0] dec_index;
    logic             dec_ti;
    logic [RPL_W-1:0] dec_rpl;
    logic             dec_null;

    sel_decode #(.SEL_W(SEL_W), .RPL_W(RPL_W)) u_dec (
        .sel     (ld_sel),
        .index   (dec_index),
        .ti      (dec_ti),
        .rpl     (dec_rpl),
        .is_null (dec_null)
    );

    tgt_classify u_cls (
        .target (ld_target),
        .tclass (tclass)
    );

    priv_rules #(.RPL_W(RPL_W)) u_rules (
        .tclass   (tclass),
        .is_null  (dec_null),
        .rpl      (dec_rpl),
        .cpl      (cur_cpl),
        .dpl      (dsc_dpl),
        .present  (dsc_present),
        .kind     (dkind_e'(dsc_kind)),
        .readable (dsc_readable),
        .writable (dsc_writable),
        .code     (verdict)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ld_valid)  state_d = ST_DONE;
            ST_DONE: if (!ld_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_accept <= 1'b0;
            res_fault  <= 1'b0;
            code_q     <= FC_NONE;
            res_index  <= '0;
            res_ti     <= 1'b0;
            res_rpl    <= '0;
        end else if (ld_valid) begin
            res_accept <= (verdict == FC_NONE);
            res_fault  <= (verdict != FC_NONE);
            code_q     <= verdict;
            res_index  <= dec_index;
            res_ti     <= dec_ti;
            res_rpl    <= dec_rpl;
        end else begin
            res_accept <= 1'b0;
            res_fault  <= 1'b0;
            code_q     <= FC_NONE;
        end
    end

    assign res_done = (state_q == ST_DONE);
    assign res_code = code_q;
endmodule

// File: rtl/seg_load_guard_chk.sv
module seg_load_guard_chk #(
    parameter int SEL_W = 16,
    parameter int RPL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ld_valid,
    input logic [2:0]       ld_target,
    input logic [SEL_W-1:0] ld_sel,
    input logic [RPL_W-1:0] cur_cpl,
    input logic             dsc_present,
    input logic [RPL_W-1:0] dsc_dpl,
    input logic             res_done,
    input logic             res_accept,
    input logic             res_fault,
    input logic [2:0]       res_code,
    input logic             res_ti,
    input logic [RPL_W-1:0] res_rpl
);
    logic req_null;
    logic req_datareg;
    assign req_null    = (ld_sel[SEL_W-1:RPL_W] == '0);
    assign req_datareg = (ld_target == 3'd0) || (ld_target == 3'd3) ||
                         (ld_target == 3'd4) || (ld_target == 3'd5);

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> res_done);
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !res_done);
    p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> (res_accept ^ res_fault) && (res_accept == (res_code == 3'd0)));
    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> !res_accept && !res_fault);
    p_cs_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_target == 3'd1) |=> res_fault && res_code == 3'd1);
    p_null_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && req_datareg && req_null) |=> res_accept);
    p_stack_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_target == 3'd2 &&
         (ld_sel[RPL_W-1:0] != cur_cpl || dsc_dpl != cur_cpl)) |=> res_fault);
    p_absent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !req_null && !dsc_present) |=> res_fault);
    p_fields_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> (res_rpl == $past(ld_sel[RPL_W-1:0])) && (res_ti == $past(ld_sel[RPL_W])));
endmodule

bind seg_load_guard seg_load_guard_chk #(.SEL_W(SEL_W), .RPL_W(RPL_W)) u_chk (.*);

// File: tb/test_seg_load_guard.sv
module test_seg_load_guard;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [2:0]  ld_target = '0;
    logic [15:0] ld_sel = '0;
    logic [1:0]  cur_cpl = '0;
    logic        dsc_present = 1'b0;
    logic [1:0]  dsc_kind = '0;
    logic        dsc_readable = 1'b0;
    logic        dsc_writable = 1'b0;
    logic [1:0]  dsc_dpl = '0;
    logic        res_done, res_accept, res_fault, res_ti;
    logic [2:0]  res_code;
    logic [12:0] res_index;
    logic [1:0]  res_rpl;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_load_guard i_seg_load_guard (
        .clk, .rst_n, .ld_valid, .ld_target, .ld_sel, .cur_cpl,
        .dsc_present, .dsc_kind, .dsc_readable, .dsc_writable, .dsc_dpl,
        .res_done, .res_accept, .res_fault, .res_code,
        .res_index, .res_ti, .res_rpl
    );

    // expected fault code from the requirements
    function automatic int exp_code(input int tgt, input logic [15:0] s, input int cpl,
                                    input bit pr, input int kind, input bit rd,
                                    input bit wr, input int dpl);
        int rpl = int'(s[1:0]);
        bit nul = (s[15:2] == 14'd0);
        if (tgt >= 6) return 6;
        if (tgt == 1) return 1;
        if (tgt == 2) begin
            if (nul) return 2;
            if (kind != 0 || !wr) return 3;
            if (rpl != cpl || dpl != cpl) return 4;
            if (!pr) return 5;
            return 0;
        end
        if (nul) return 0;
        if (kind == 3 || (kind != 0 && !rd)) return 3;
        if (kind != 2 && (rpl > dpl || cpl > dpl)) return 4;
        if (!pr) return 5;
        return 0;
    endfunction

    function automatic string tag_of(input int code, input int tgt, input logic [15:0] s,
                                     input int kind);
        case (code)
            1: return "R3";
            2: return "R5";
            3: return (tgt == 2) ? "R6" : "R8";
            4: return (tgt == 2) ? "R7" : "R9";
            5: return "R11";
            6: return "R4";
            default: begin
                if (s[15:2] == 14'd0) return "R5";
                if (kind == 2 && tgt != 2) return "R10";
                return "R12";
            end
        endcase
    endfunction

    task automatic apply(input string tag, input int tgt, input logic [15:0] s, input int cpl,
                         input bit pr, input int kind, input bit rd, input bit wr, input int dpl);
        int ec;
        @(negedge clk);
        ld_valid = 1'b1; ld_target = 3'(tgt); ld_sel = s; cur_cpl = 2'(cpl);
        dsc_present = pr; dsc_kind = 2'(kind); dsc_readable = rd;
        dsc_writable = wr; dsc_dpl = 2'(dpl);
        ec = exp_code(tgt, s, cpl, pr, kind, rd, wr, dpl);
        if (tag == "") tag = tag_of(ec, tgt, s, kind);
        @(negedge clk);
        checks++;
        if (res_done !== 1'b1 || res_accept !== (ec == 0) || res_fault !== (ec != 0) ||
            res_code !== 3'(ec) || res_index !== s[15:3] || res_ti !== s[2] ||
            res_rpl !== s[1:0]) begin
            failures++;
            $display("FAIL %s: got done=%b acc=%b flt=%b code=%0d idx=%0d ti=%b rpl=%0d expected done=1 acc=%b flt=%b code=%0d idx=%0d ti=%b rpl=%0d",
                     tag, res_done, res_accept, res_fault, res_code, res_index, res_ti, res_rpl,
                     ec == 0, ec != 0, ec, s[15:3], s[2], s[1:0]);
        end
    endtask

    task automatic go_idle(input string tag);
        @(negedge clk);
        ld_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (res_done !== 1'b0 || res_accept !== 1'b0 || res_fault !== 1'b0 || res_code !== 3'd0) begin
            failures++;
            $display("FAIL %s: got done=%b acc=%b flt=%b code=%0d expected done=0 acc=0 flt=0 code=0",
                     tag, res_done, res_accept, res_fault, res_code);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0C0D);
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_done !== 1'b0 || res_accept !== 1'b0 || res_fault !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: got done=%b acc=%b flt=%b expected 0 0 0",
                     res_done, res_accept, res_fault);
        end
        rst_n = 1'b1;

        // directed corner cases
        apply("R3",  1, 16'h0010, 0, 1, 0, 1, 1, 0);
        apply("R4",  6, 16'h0010, 0, 1, 0, 1, 1, 0);
        apply("R4",  7, 16'h0000, 3, 0, 3, 0, 0, 1);
        apply("R5",  2, 16'h0003, 3, 1, 0, 1, 1, 3);
        apply("R5",  3, 16'h0003, 0, 0, 3, 0, 0, 0);
        apply("R5",  5, 16'h0000, 3, 0, 1, 0, 0, 0);
        apply("R6",  2, 16'h0020, 0, 1, 0, 1, 0, 0);
        apply("R6",  2, 16'h0020, 0, 1, 1, 1, 1, 0);
        apply("R7",  2, 16'h0021, 0, 1, 0, 1, 1, 0);
        apply("R7",  2, 16'h0022, 2, 1, 0, 1, 1, 3);
        apply("R8",  4, 16'h0048, 0, 1, 3, 1, 1, 3);
        apply("R8",  0, 16'h0048, 0, 1, 1, 0, 1, 3);
        apply("R9",  3, 16'h0049, 0, 1, 0, 0, 0, 0);
        apply("R9",  3, 16'h0048, 3, 1, 1, 1, 0, 2);
        apply("R10", 3, 16'h004B, 3, 1, 2, 1, 0, 0);
        apply("R8",  3, 16'h004B, 3, 1, 2, 0, 0, 0);
        apply("R11", 5, 16'h0050, 1, 0, 0, 1, 0, 2);
        apply("R11", 2, 16'h0051, 1, 0, 0, 0, 1, 1);
        apply("R13", 2, 16'h0061, 0, 0, 1, 1, 0, 3);
        apply("R13", 4, 16'h0063, 0, 0, 3, 0, 0, 0);
        apply("R12", 2, 16'hFFFE, 2, 1, 0, 0, 1, 2);
        go_idle("R1");
        apply("R2",  3, 16'h1234, 0, 1, 0, 0, 0, 3);
        go_idle("R2");

        // constrained random, back-to-back and with gaps
        for (int i = 0; i < 400; i++) begin
            int tgt = ($urandom % 8 < 7) ? int'($urandom % 6) : int'(6 + $urandom % 2);
            int cpl = int'($urandom % 4);
            int dpl = ($urandom % 2 == 0) ? cpl : int'($urandom % 4);
            logic [15:0] s = 16'($urandom);
            if ($urandom % 2 == 0) s[1:0] = 2'(cpl);
            if ($urandom % 8 == 0) s[15:2] = '0;
            apply("", tgt, s, cpl, ($urandom % 6) != 0, int'($urandom % 4),
                  1'($urandom), 1'($urandom), dpl);
            if ($urandom % 10 == 0) go_idle("R1");
        end
        go_idle("R1");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule